// File: doc/BRIEF.md
# Radix-4 Recoded Signed Array Multiplier

This block multiplies two signed two's-complement operands of `N` bits each (`N` even, default 8) and returns the full `2N`-bit signed product. The multiplier operand is split into `N/2` radix-4 digits. Every digit is recoded at the same time, from its own overlapping three-bit window, into the set {-2,-1,0,+1,+2}. No carry passes from one digit to the next, so all recoders work in parallel.

Each digit's recoder steers a multiple generator. The generator picks zero, the multiplicand, or the multiplicand shifted left by one, and inverts every bit when the digit is negative. A "+1" correction for each negative digit goes in at the least significant bit of that digit's row. Rows are not sign extended. The sign bit of each row is complemented instead, and one constant bias word corrects the result. That bias and all the row carry-ins share a single correction row.

The `N/2` partial-product rows and the correction row are summed by a linear chain of 3:2 carry-save adders. A final carry-propagate adder produces the product, which is captured in an output register. The product appears one clock after the operands are presented. It is zero while reset is held.

Top module: `mul_r4_array`

## Requirements
- R1: While `rst_n` is low, `prod_o` is all zeros on every cycle.
- R2: The product is registered. The value on `prod_o` after a rising edge corresponds to the operands that were present at that edge.
- R3: `prod_o` equals the exact signed product of `mcand_i` and `mplier_i`, both read as two's complement, for every pair of operand values. The product is `2N` bits wide and never wraps.
- R4: Digit j is recoded from the window (bit 2j+1, bit 2j, bit 2j-1) of the multiplier, with bit -1 taken as 0. The window maps as follows: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1. A multiplier whose only non-zero digits fall in the lowest window gives the multiplicand times that digit.
- R5: A zero multiplier gives a zero product for any multiplicand. A zero digit contributes no multiple and no carry-in.
- R6: The most negative value times itself gives +2^(2N-2). The most negative value times +1 and times -1 is also exact.
- R7: A multiplier of all ones (-1) gives the two's-complement negation of the multiplicand, sign extended to `2N` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register loads on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| mcand_i | input | N | Multiplicand, two's complement |
| mplier_i | input | N | Multiplier, two's complement; recoded into radix-4 digits |
| prod_o | output | 2N | Registered signed product |

## Verification
Every product is due exactly one rising edge after its operands. The bench changes operands on the falling edge and pushes the expected product into a queue. It pops and compares one falling edge later, half a period after the register has loaded, so each comparison lines up with the single register stage. The expected value is the bench's own integer multiplication of the two signed operands. With the default width, the bench applies every operand pair in addition to directed digit, zero, negation and extreme-value cases. During reset, the bench checks for an all-zero output on each cycle.

// File: rtl/mul_r4_pkg.sv
package mul_r4_pkg;

    typedef struct packed {
        logic neg;   // digit is negative: invert multiple, inject +1
        logic one;   // |digit| == 1
        logic two;   // |digit| == 2
    } r4_ctl_t;

    // Bias that replaces the removed sign extension of every row:
    // minus the sum of 2^(n+2j) over all rows, kept to 128 bits.
    function automatic logic [127:0] sign_bias(input int n);
        logic [127:0] acc;
        acc = '0;
        for (int j = 0; j < n / 2; j++) begin
            acc = acc + (128'(1) << (n + 2 * j));
        end
        return (~acc) + 128'(1);
    endfunction

endpackage

// File: rtl/r4_recoder.sv
module r4_recoder
    import mul_r4_pkg::*;
(
    input  logic [2:0] window_i,   // {y[2j+1], y[2j], y[2j-1]}
    output r4_ctl_t    ctl_o
);
    logic hi, mid, lo;

    always_comb begin
        hi  = window_i[2];
        mid = window_i[1];
        lo  = window_i[0];
        // negative only when the digit is non-zero (111 is a zero digit)
        ctl_o.neg = hi & ~(mid & lo);
        ctl_o.one = mid ^ lo;
        ctl_o.two = (hi & ~mid & ~lo) | (~hi & mid & lo);
    end
endmodule

// File: rtl/r4_multiple.sv
module r4_multiple
    import mul_r4_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] x_i,
    input  r4_ctl_t      ctl_i,
    output logic [N:0]   row_o     // N+1-bit signed multiple, inverted if negative
);
    logic [N:0] x1, x2, pick;

    always_comb begin
        x1 = {x_i[N-1], x_i};
        x2 = {x_i, 1'b0};
        unique case (1'b1)
            ctl_i.two: pick = x2;
            ctl_i.one: pick = x1;
            default:   pick = '0;
        endcase
        row_o = pick ^ {(N+1){ctl_i.neg}};
    end
endmodule

// File: rtl/csa32.sv
module csa32 #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cry_o
);
    always_comb begin
        sum_o = a_i ^ b_i ^ c_i;
        cry_o = {(a_i[W-2:0] & b_i[W-2:0]) |
                 (a_i[W-2:0] & c_i[W-2:0]) |
                 (b_i[W-2:0] & c_i[W-2:0]), 1'b0};
    end
endmodule

// File: rtl/mul_r4_array.sv
module mul_r4_array
    import mul_r4_pkg::*;
#(
    parameter int N = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    mcand_i,
    input  logic [N-1:0]    mplier_i,
    output logic [2*N-1:0]  prod_o
);
    localparam int PW   = 2 * N;
    localparam int ROWS = N / 2;
    localparam logic [127:0]  BIAS_W = sign_bias(N);
    localparam logic [PW-1:0] BIAS   = BIAS_W[PW-1:0];

    logic [N:0]    ymx;                 // multiplier with y[-1] = 0 appended
    r4_ctl_t       ctl   [ROWS];
    logic [N:0]    mult  [ROWS];
    logic [PW-1:0] row   [ROWS];
    logic [PW-1:0] corr;
    logic [PW-1:0] s_ch  [ROWS];
    logic [PW-1:0] c_ch  [ROWS];
    logic [PW-1:0] prod_d;

    assign ymx = {mplier_i, 1'b0};

    for (genvar j = 0; j < ROWS; j++) begin : g_digit
        r4_recoder u_rec (
            .window_i (ymx[2*j+2 -: 3]),
            .ctl_o    (ctl[j])
        );
        r4_multiple #(.N(N)) u_mul (
            .x_i   (mcand_i),
            .ctl_i (ctl[j]),
            .row_o (mult[j])
        );
        // complemented sign bit, no replication; placed at weight 4^j
        assign row[j] = PW'({~mult[j][N], mult[j][N-1:0]}) << (2 * j);
    end

    // carry-ins sit at bits 2j (< N), bias sits at bits >= N: disjoint
    always_comb begin
        corr = BIAS;
        for (int j = 0; j < ROWS; j++) begin
            corr[2*j] = ctl[j].neg;
        end
    end

    assign s_ch[0] = row[0];
    assign c_ch[0] = corr;

    for (genvar j = 1; j < ROWS; j++) begin : g_csa
        csa32 #(.W(PW)) u_csa (
            .a_i   (s_ch[j-1]),
            .b_i   (c_ch[j-1]),
            .c_i   (row[j]),
            .sum_o (s_ch[j]),
            .cry_o (c_ch[j])
        );
    end

    assign prod_d = s_ch[ROWS-1] + c_ch[ROWS-1];

    always_ff @(posedge clk) begin
        if (!rst_n) prod_o <= '0;
        else        prod_o <= prod_d;
    end
endmodule

// File: rtl/mul_r4_checker.sv
module mul_r4_checker #(
    parameter int N = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    mcand_i,
    input logic [N-1:0]    mplier_i,
    input logic [2*N-1:0]  prod_o
);
    localparam int PW = 2 * N;

    logic signed [PW-1:0] sa, sb, ref_prod, neg_a;
    logic                 b_zero, b_ones, ext_pair;

    always_comb begin
        sa       = PW'($signed(mcand_i));
        sb       = PW'($signed(mplier_i));
        ref_prod = sa * sb;
        neg_a    = -sa;
        b_zero   = (mplier_i == '0);
        b_ones   = (mplier_i == '1);
        ext_pair = (mcand_i == {1'b1, {(N-1){1'b0}}}) &&
                   (mplier_i == {1'b1, {(N-1){1'b0}}});
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (prod_o == '0));                                    // R1

    AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (prod_o == $past(ref_prod)));                 // R2

    AST_ZERO_MPLIER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(b_zero)) |-> (prod_o == '0));           // R5

    AST_MINUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(b_ones)) |-> (prod_o == $past(neg_a))); // R7

    AST_EXTREME_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ext_pair)) |->
            (prod_o == (PW'(1) << (PW - 2))));                         // R6
endmodule

bind mul_r4_array mul_r4_checker #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .prod_o   (prod_o)
);

// File: tb/tb_mul_r4_array.sv
module tb_mul_r4_array;
    localparam int N        = 8;
    localparam int PW       = 2 * N;
    localparam int CLK_PER  = 10;
    localparam int WD_LIMIT = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  a_i = '0;
    logic [N-1:0]  b_i = '0;
    logic [PW-1:0] prod;

    int applied = 0;
    int bad     = 0;

    logic [PW-1:0] exp_q [$];
    string         tag_q [$];
    logic [N-1:0]  a_q   [$];
    logic [N-1:0]  b_q   [$];

    localparam logic [N-1:0] MINV = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] MAXV = {1'b0, {(N-1){1'b1}}};

    mul_r4_array #(.N(N)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mcand_i  (a_i),
        .mplier_i (b_i),
        .prod_o   (prod)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic logic [PW-1:0] model(input logic [N-1:0] a, input logic [N-1:0] b);
        longint sa, sb;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        return PW'(sa * sb);
    endfunction

    task automatic compare_one();
        logic [PW-1:0] e;
        string t;
        logic [N-1:0] qa, qb;
        if (exp_q.size() > 0) begin
            e  = exp_q.pop_front();
            t  = tag_q.pop_front();
            qa = a_q.pop_front();
            qb = b_q.pop_front();
            applied++;
            if (prod !== e) begin
                bad++;
                $display("FAIL %s: a=%0d b=%0d got %h expected %h",
                         t, $signed(qa), $signed(qb), prod, e);
            end
        end
    endtask

    // one cycle: check what is due, then present new operands
    task automatic step(input logic [N-1:0] a, input logic [N-1:0] b, input string t);
        @(negedge clk);
        compare_one();
        a_i = a;
        b_i = b;
        exp_q.push_back(model(a, b));
        tag_q.push_back(t);
        a_q.push_back(a);
        b_q.push_back(b);
    endtask

    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin : main
        // R1: output held at zero during reset, even with operands applied
        a_i = 8'h55;
        b_i = 8'h33;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            applied++;
            if (prod !== '0) begin
                bad++;
                $display("FAIL R1: got %h expected %h", prod, {PW{1'b0}});
            end
        end
        rst_n = 1'b1;

        // R2: back-to-back changes, each due one edge later
        step(8'd3,  8'd5,  "R2");
        step(8'd7,  8'hFD, "R2");
        step(8'hF0, 8'd9,  "R2");

        // R5: zero multiplier
        step(MAXV, '0, "R5");
        step(MINV, '0, "R5");
        step(8'hA5, '0, "R5");

        // R7: multiplier of -1
        step(8'd1,  '1, "R7");
        step(MAXV,  '1, "R7");
        step(MINV,  '1, "R7");
        step(8'hC3, '1, "R7");

        // R6: extreme values
        step(MINV, MINV, "R6");
        step(MINV, 8'd1, "R6");
        step(MAXV, MAXV, "R6");
        step(MINV, MAXV, "R6");

        // R4: each window pattern of the lowest digit, and one higher digit
        for (int v = -4; v < 4; v++) begin
            step(8'd37, N'(v), "R4");
            step(MINV,  N'(v), "R4");
        end
        step(8'd11, 8'h20, "R4");
        step(8'd11, 8'hC0, "R4");

        // R3: every operand pair
        for (int i = 0; i < (1 << N); i++) begin
            for (int j = 0; j < (1 << N); j++) begin
                step(N'(i), N'(j), "R3");
            end
        end

        @(negedge clk);
        compare_one();
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule